// File: doc/BRIEF.md
# Timed Configuration Byte Readback Controller

This block sits next to the program-memory read path of a small CPU and lets software read its configuration fuse bytes and lock bits. Software writes a two-bit control register, setting an enable bit and a read-config bit together. That write opens a short unlock window. A program-memory load issued early in the window is answered with a configuration byte instead of flash data. The 16-bit load pointer chooses which byte comes back.

The window closes by itself. An answered load closes it. A store inside the window closes it. If neither happens, it closes once its store limit has run out. After that, loads see ordinary flash data again. While an EEPROM write is in progress, control writes are ignored and no configuration byte is returned. The stored configuration inputs carry one flag per bit, where 1 means programmed. The returned byte reads programmed bits as 0.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: Inside the window, pointer 0x0000 returns the low fuse byte, 0x0001 returns the lock byte and 0x0003 returns the high fuse byte.
- R2: Control data bit 0 is the enable bit and bit 1 is the read-config bit. The window opens at the clock edge that registers a write setting both bits. A load strobe during the first LOAD_WIN (3) cycles after that edge raises `cfg_sel` in the same cycle and presents the configuration byte.
- R3: After an answered load, both control bits are clear, so a following load gets flash data (`cfg_sel` low).
- R4: A load issued LOAD_WIN or more cycles after the opening edge is not answered. Both bits clear by themselves after STORE_WIN (4) cycles.
- R5: Whenever `cfg_sel` is low, `rd_data` is 0x00.
- R6: A configuration bit flagged as programmed reads as 0, and an unprogrammed one reads as 1.
- R7: In the lock byte, bits 1:0 carry the lock bits and bits 7:2 read as 1.
- R8: While `ee_busy` is high, a control write leaves the register unchanged and no load is answered.
- R9: Inside the window, any other pointer value returns 0xFF and still closes the window.
- R10: After reset both control bits and the cycle counter are clear.
- R11: A control write that sets both bits again restarts the window count from zero.
- R12: A store strobe while both bits are set closes the window without a configuration read.
- R13: A write that sets only one of the two bits does not open the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 enable, bit 1 read-config) |
| ld_strobe | input | 1 | Program-memory load executing this cycle |
| st_strobe | input | 1 | Program-memory store executing this cycle |
| ptr | input | 16 | Load pointer value |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_lo_prog | input | 8 | Low fuse byte, 1 = programmed |
| fuse_hi_prog | input | 8 | High fuse byte, 1 = programmed |
| lock_prog | input | 2 | Lock bits, 1 = programmed |
| cfg_sel | output | 1 | Selects configuration data on the load data mux |
| rd_data | output | 8 | Configuration byte, 0x00 when not selected |

## Verification
On every cycle, the assertions check the following:
- `cfg_sel` never rises outside the load part of the window or during an EEPROM write.
- An answered load, a store or an expired count always closes the window.
- A busy write never opens it.
- The output is zero when not selected, and the lock byte's upper bits are ones.

Only the bench's scenarios can show the rest:
- The exact cycle boundary of the load window.
- The restart on a repeated write.
- The mapping and inversion of each byte across pointer values and bit patterns.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;

    localparam int PTR_W = 16;
    localparam int BYTE_W = 8;
    localparam int LOCK_W = 2;

    localparam logic [PTR_W-1:0] PTR_FUSE_LO = 16'h0000;
    localparam logic [PTR_W-1:0] PTR_LOCK    = 16'h0001;
    localparam logic [PTR_W-1:0] PTR_FUSE_HI = 16'h0003;

    localparam int CTL_EN_BIT = 0;
    localparam int CTL_RD_BIT = 1;

    typedef enum logic [1:0] {
        SRC_FUSE_LO,
        SRC_LOCK,
        SRC_FUSE_HI,
        SRC_NONE
    } cfg_src_e;

    function automatic cfg_src_e decode_ptr(input logic [PTR_W-1:0] p);
        cfg_src_e s;
        case (p)
            PTR_FUSE_LO: s = SRC_FUSE_LO;
            PTR_LOCK:    s = SRC_LOCK;
            PTR_FUSE_HI: s = SRC_FUSE_HI;
            default:     s = SRC_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
    import cfg_rb_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    parameter int CNT_W     = $clog2(STORE_WIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             wr_en_bit,
    input  logic             wr_rd_bit,
    input  logic             ld_strobe,
    input  logic             st_strobe,
    input  logic             ee_busy,
    output logic             load_hit,
    output logic             en_o,
    output logic             rd_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LOAD_LIM  = CNT_W'(LOAD_WIN);
    localparam logic [CNT_W-1:0] STORE_END = CNT_W'(STORE_WIN - 1);

    typedef struct packed {
        logic             en;
        logic             rd;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st_d, st_q;
    logic armed;

    always_comb begin
        st_d     = st_q;
        armed    = st_q.en && st_q.rd;
        load_hit = armed && ld_strobe && !ee_busy && (st_q.cnt < LOAD_LIM);

        if (st_q.en || st_q.rd) begin
            if (st_q.cnt == STORE_END) begin
                st_d.en  = 1'b0;
                st_d.rd  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (load_hit || (armed && st_strobe)) begin
            st_d.en  = 1'b0;
            st_d.rd  = 1'b0;
            st_d.cnt = '0;
        end

        if (ctl_wr && !ee_busy) begin
            st_d.en  = wr_en_bit;
            st_d.rd  = wr_rd_bit;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign rd_o  = st_q.rd;
    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/cfg_byte_sel.sv
module cfg_byte_sel
    import cfg_rb_pkg::*;
(
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] fuse_lo_prog,
    input  logic [BYTE_W-1:0] fuse_hi_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic [BYTE_W-1:0] cfg_byte
);

    cfg_src_e src;

    always_comb begin
        src = decode_ptr(ptr);
        case (src)
            SRC_FUSE_LO: cfg_byte = ~fuse_lo_prog;
            SRC_LOCK:    cfg_byte = {{(BYTE_W-LOCK_W){1'b1}}, ~lock_prog};
            SRC_FUSE_HI: cfg_byte = ~fuse_hi_prog;
            default:     cfg_byte = '1;
        endcase
    end

endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
    import cfg_rb_pkg::*;
#(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    localparam int CNT_W    = $clog2(STORE_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              ld_strobe,
    input  logic              st_strobe,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              ee_busy,
    input  logic [BYTE_W-1:0] fuse_lo_prog,
    input  logic [BYTE_W-1:0] fuse_hi_prog,
    input  logic [LOCK_W-1:0] lock_prog,
    output logic              cfg_sel,
    output logic [BYTE_W-1:0] rd_data
);

    logic             win_en;
    logic             win_rd;
    logic [CNT_W-1:0] win_cnt;
    logic             load_hit;
    logic [BYTE_W-1:0] cfg_byte;
    logic             unused_wdata;

    assign unused_wdata = ^ctl_wdata[7:2];

    cfg_window_ctrl #(
        .LOAD_WIN (LOAD_WIN),
        .STORE_WIN(STORE_WIN),
        .CNT_W    (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wr_en_bit(ctl_wdata[CTL_EN_BIT]),
        .wr_rd_bit(ctl_wdata[CTL_RD_BIT]),
        .ld_strobe(ld_strobe),
        .st_strobe(st_strobe),
        .ee_busy  (ee_busy),
        .load_hit (load_hit),
        .en_o     (win_en),
        .rd_o     (win_rd),
        .cnt_o    (win_cnt)
    );

    cfg_byte_sel u_sel (
        .ptr         (ptr),
        .fuse_lo_prog(fuse_lo_prog),
        .fuse_hi_prog(fuse_hi_prog),
        .lock_prog   (lock_prog),
        .cfg_byte    (cfg_byte)
    );

    assign cfg_sel = load_hit;
    assign rd_data = load_hit ? cfg_byte : '0;

endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk #(
    parameter int LOAD_WIN  = 3,
    parameter int STORE_WIN = 4,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ld_strobe,
    input logic             st_strobe,
    input logic [15:0]      ptr,
    input logic             ee_busy,
    input logic             cfg_sel,
    input logic [7:0]       rd_data,
    input logic             win_en,
    input logic             win_rd,
    input logic [CNT_W-1:0] win_cnt
);

    p_sel_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> (win_en && win_rd && ld_strobe && (int'(win_cnt) < LOAD_WIN)));

    p_clear_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && !ctl_wr) |=> (!win_en && !win_rd));

    p_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && (int'(win_cnt) == STORE_WIN - 1) && !ctl_wr) |=> !win_en);

    p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |-> (rd_data == 8'h00));

    p_lock_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && ptr == 16'h0001) |-> (rd_data[7:2] == 6'h3f));

    p_busy_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |-> !cfg_sel);

    p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ee_busy && !win_en && !win_rd) |=> (!win_en && !win_rd));

    p_store_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_strobe && win_en && win_rd && !ctl_wr) |=> (!win_en && !win_rd));

endmodule

bind cfg_readback_ctrl cfg_readback_chk #(
    .LOAD_WIN (LOAD_WIN),
    .STORE_WIN(STORE_WIN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ld_strobe(ld_strobe),
    .st_strobe(st_strobe),
    .ptr      (ptr),
    .ee_busy  (ee_busy),
    .cfg_sel  (cfg_sel),
    .rd_data  (rd_data),
    .win_en   (win_en),
    .win_rd   (win_rd),
    .win_cnt  (win_cnt)
);

// File: tb/tb_cfg_readback_ctrl.sv
module tb_cfg_readback_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        ld_strobe = 1'b0;
    logic        st_strobe = 1'b0;
    logic [15:0] ptr = 16'h0000;
    logic        ee_busy = 1'b0;
    logic [7:0]  fuse_lo_prog = 8'h00;
    logic [7:0]  fuse_hi_prog = 8'h00;
    logic [1:0]  lock_prog = 2'b00;
    logic        cfg_sel;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_readback_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ld_strobe(ld_strobe), .st_strobe(st_strobe), .ptr(ptr), .ee_busy(ee_busy),
        .fuse_lo_prog(fuse_lo_prog), .fuse_hi_prog(fuse_hi_prog), .lock_prog(lock_prog),
        .cfg_sel(cfg_sel), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_byte(input logic [15:0] p);
        case (p)
            16'h0000: return ~fuse_lo_prog;
            16'h0001: return {6'h3f, ~lock_prog};
            16'h0003: return ~fuse_hi_prog;
            default:  return 8'hff;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual {sel,data}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] d, input bit busy);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d; ee_busy = busy;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 8'h00; ee_busy = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue a load in the current cycle, sample before the next edge, then leave the cycle.
    task automatic load_check(input logic [15:0] p, input bit exp_sel, input string req);
        logic [7:0] e;
        ptr = p; ld_strobe = 1'b1;
        #1;
        e = exp_sel ? exp_byte(p) : 8'h00;
        check(cfg_sel == exp_sel && rd_data == e, req, {cfg_sel, rd_data}, {exp_sel, e});
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] ptrs [7];
        ptrs = '{16'h0000, 16'h0001, 16'h0003, 16'h0002, 16'h0004, 16'h8000, 16'hffff};
        idle(3);
        // R10: reset state, a load finds the window closed
        @(negedge clk);
        load_check(16'h0000, 1'b0, "R10 reset");
        rst_n = 1'b1;
        idle(1);
        load_check(16'h0001, 1'b0, "R10 after reset");

        // R2/R4: window boundary sweep over delay after the opening edge
        for (int d = 0; d < 7; d++) begin
            ctl_write(8'h03, 1'b0);
            idle(d);
            load_check(16'h0000, d < 3, $sformatf("R2/R4 delay %0d", d));
            idle(5);
            load_check(16'h0000, 1'b0, "R4 closed later");
        end

        // R1/R6/R7/R9/R3: pointer x bit-pattern sweep
        for (int pat = 0; pat < 8; pat++) begin
            fuse_lo_prog = 8'(pat * 37 + 5);
            fuse_hi_prog = 8'(pat * 91 + 200);
            lock_prog    = 2'(pat);
            for (int i = 0; i < 7; i++) begin
                ctl_write(8'h03, 1'b0);
                idle(i % 3);
                load_check(ptrs[i], 1'b1, "R1/R6/R7/R9 map");
                load_check(ptrs[i], 1'b0, "R3/R9 closed after read");
            end
        end

        // R11: restart on repeated write
        ctl_write(8'h03, 1'b0);
        idle(1);
        ctl_write(8'h03, 1'b0);
        idle(2);
        load_check(16'h0003, 1'b1, "R11 restart");

        // R12: store closes the window
        ctl_write(8'h03, 1'b0);
        st_strobe = 1'b1;
        @(negedge clk);
        st_strobe = 1'b0;
        load_check(16'h0000, 1'b0, "R12 store close");

        // R8: busy write ignored
        ctl_write(8'h03, 1'b1);
        load_check(16'h0000, 1'b0, "R8 busy write");
        // R8: busy during load blocks the read
        ctl_write(8'h03, 1'b0);
        ee_busy = 1'b1;
        load_check(16'h0001, 1'b0, "R8 busy load");
        ee_busy = 1'b0;
        load_check(16'h0001, 1'b1, "R8 window survives busy");

        // R13: one bit alone does not open
        ctl_write(8'h01, 1'b0);
        load_check(16'h0000, 1'b0, "R13 enable only");
        ctl_write(8'h02, 1'b0);
        load_check(16'h0000, 1'b0, "R13 read-config only");

        // R5: no load strobe -> deselected, zero data
        ctl_write(8'h03, 1'b0);
        ptr = 16'h0001;
        #1;
        check(cfg_sel == 1'b0 && rd_data == 8'h00, "R5 idle zero", {cfg_sel, rd_data}, 9'h000);
        idle(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule